// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block turns a stream of angles into their cosine and sine. It uses rotation-mode CORDIC and unrolls it completely. Each of the eleven micro-rotations has its own hardware stage, with a register after it, so every stage works on a different sample in the same cycle. A new angle can therefore enter on every clock. Each stage picks its rotation direction from the sign of the residual angle it receives. It shifts the opposite coordinate by its own stage index, adds or subtracts that value, and moves the residual angle by a fixed arctangent constant for that stage.

The injected start vector is (1.0, 0), and the residual angle starts at the input angle. Because of this, the rotated vector grows by the usual CORDIC gain. The last stage removes that growth. It does its own micro-rotation and, in the same cycle, multiplies both coordinates by the precomputed inverse gain, using two multipliers side by side. A valid flag moves through the pipeline with each sample. The host drives an angle with a strobe and receives cosine and sine with a matching strobe, a fixed number of cycles later. The input range is limited to the convergence range of about ±1.74 rad. The block does no quadrant folding.

Top module: `cordic_sincos`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and on the first clock after it, `out_valid`, `cos_out` and `sin_out` are zero. A reset discards every sample that is in flight, so none of them ever appears at the output.
- R2: A sample captured with `in_valid` high on a clock edge appears with `out_valid` high exactly 11 clock edges later (one edge per iteration stage).
- R3: Samples may arrive on consecutive cycles. They leave in arrival order, one per cycle, and none is dropped or duplicated.
- R4: For any input angle with |`in_angle`| ≤ 7100, `cos_out` is within 10 LSB of round(4096·cos(`in_angle`/4096)).
- R5: Under the same input range, `sin_out` is within 10 LSB of round(4096·sin(`in_angle`/4096)).
- R6: `in_angle`, `cos_out` and `sin_out` are signed 16-bit two's-complement values with 12 fraction bits, so 4096 stands for 1.0 (radians for the angle). An input angle of 0 gives a cosine near 4096 and a sine near 0.
- R7: The gain is compensated, so for every valid output cos² + sin² lies within 2^24 ± 2^17.
- R8: Angles at the edge of the convergence range (±7100) still meet R4 and R5. The residual angle that reaches the last stage is at most (4096 >> 8) + 22 LSB in magnitude.
- R9: In a cycle where `in_valid` is low, `in_angle` has no effect. That cycle produces no valid output, and it does not change any other sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that marks `in_angle` as a sample |
| in_angle | input | 16 | Angle in radians, signed, 12 fraction bits |
| out_valid | output | 1 | Strobe that marks the result outputs |
| cos_out | output | 16 | Cosine, signed, 12 fraction bits |
| sin_out | output | 16 | Sine, signed, 12 fraction bits |

## Verification
The bench builds the block with its default parameters: eleven iterations and an inverse gain of 2487. With these values the full eleven-deep pipeline is exercised, and both the fixed 11-cycle latency and the 10-LSB error bound can be observed at the ports. Directed angles cover zero, ±1 LSB, ±π/4, ±π/2 and ±7100, which is the edge of the convergence range. Seeded random streams with gaps test ordering, gap handling and the accuracy against a real-valued reference. A reset in the middle of a stream checks that the samples in flight are flushed.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int DATA_W  = 16;
    localparam int FRAC_W  = 12;
    localparam int N_ITER  = 11;
    localparam int GAIN_Q  = 2487;
    localparam int WIDE_W  = 2 * DATA_W;

    typedef logic signed [DATA_W-1:0] q_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic vld;
        q_t   x;
        q_t   y;
        q_t   z;
    } rot_t;

    localparam q_t ONE_Q = q_t'(1 << FRAC_W);

    // arctangent of 2^-i, scaled by 2^FRAC_W and rounded
    function automatic q_t atan_q(input int i);
        case (i)
            0:       atan_q = q_t'(3217);
            1:       atan_q = q_t'(1899);
            2:       atan_q = q_t'(1003);
            3:       atan_q = q_t'(509);
            4:       atan_q = q_t'(256);
            5:       atan_q = q_t'(128);
            6:       atan_q = q_t'(64);
            default: atan_q = q_t'((1 << FRAC_W) >> i);
        endcase
    endfunction

    // one micro-rotation: direction from the sign of the residual angle
    function automatic rot_t rotate(input rot_t d, input int sh);
        rot_t r;
        q_t   xs;
        q_t   ys;
        q_t   at;
        xs = d.x >>> sh;
        ys = d.y >>> sh;
        at = atan_q(sh);
        r.vld = d.vld;
        if (!d.z[DATA_W-1]) begin
            r.x = d.x - ys;
            r.y = d.y + xs;
            r.z = d.z - at;
        end else begin
            r.x = d.x + ys;
            r.y = d.y - xs;
            r.z = d.z + at;
        end
        return r;
    endfunction

endpackage

// File: rtl/cordic_iter.sv
module cordic_iter
    import cordic_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic clk,
    input  logic rst,
    input  rot_t d_i,
    output rot_t d_o
);

    rot_t nxt;

    always_comb begin
        nxt = rotate(d_i, SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_o <= '0;
        end else begin
            d_o <= nxt;
        end
    end

    // R2: each stage delays the valid flag by exactly one edge
    a_r2_valid_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (d_o.vld == $past(d_i.vld)));

endmodule

// File: rtl/cordic_last.sv
module cordic_last
    import cordic_pkg::*;
#(
    parameter int SHIFT   = N_ITER - 1,
    parameter int GAIN    = GAIN_Q,
    parameter int Z_BOUND = 38
) (
    input  logic clk,
    input  logic rst,
    input  rot_t d_i,
    output logic vld_o,
    output q_t   cos_o,
    output q_t   sin_o
);

    localparam q_t K_Q = q_t'(GAIN);

    rot_t  rot;
    wide_t px;
    wide_t py;

    always_comb begin
        rot = rotate(d_i, SHIFT);
        px  = wide_t'(rot.x) * wide_t'(K_Q);
        py  = wide_t'(rot.y) * wide_t'(K_Q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            vld_o <= rot.vld;
            cos_o <= q_t'(px >>> FRAC_W);
            sin_o <= q_t'(py >>> FRAC_W);
        end
    end

    longint nrm;
    always_comb begin
        nrm = longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o);
    end

    // R1: output is quiet on the edge after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vld_o && cos_o == '0 && sin_o == '0));

    // R7: gain compensation keeps the result on the unit circle
    a_r7_unit_norm: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (nrm >= 64'sd16646144 && nrm <= 64'sd16908288));

    // R8: residual angle reaching the final stage has converged
    a_r8_residual: assert property (@(posedge clk) disable iff (rst)
        d_i.vld |-> (int'(d_i.z) <= Z_BOUND && int'(d_i.z) >= -Z_BOUND));

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
    import cordic_pkg::*;
#(
    parameter int N_STAGES = cordic_pkg::N_ITER,
    parameter int INV_GAIN = cordic_pkg::GAIN_Q
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic signed [cordic_pkg::DATA_W-1:0]  in_angle,
    output logic                                  out_valid,
    output logic signed [cordic_pkg::DATA_W-1:0]  cos_out,
    output logic signed [cordic_pkg::DATA_W-1:0]  sin_out
);

    localparam int ZB = ((1 << FRAC_W) >> (N_STAGES - 3)) + 2 * N_STAGES;

    rot_t chain [N_STAGES];

    // initial vector injection: x = 1.0, y = 0, z = angle
    always_comb begin
        chain[0].vld = in_valid;
        chain[0].x   = ONE_Q;
        chain[0].y   = '0;
        chain[0].z   = in_angle;
    end

    for (genvar g = 0; g < N_STAGES - 1; g++) begin : g_stage
        cordic_iter #(.SHIFT(g)) u_iter (
            .clk (clk),
            .rst (rst),
            .d_i (chain[g]),
            .d_o (chain[g+1])
        );
    end

    cordic_last #(
        .SHIFT   (N_STAGES - 1),
        .GAIN    (INV_GAIN),
        .Z_BOUND (ZB)
    ) u_last (
        .clk   (clk),
        .rst   (rst),
        .d_i   (chain[N_STAGES-1]),
        .vld_o (out_valid),
        .cos_o (cos_out),
        .sin_o (sin_out)
    );

endmodule

// File: tb/cordic_sincos_test.sv
`timescale 1ns/1ps
module cordic_sincos_test;

    localparam int LAT  = 11;
    localparam int TOL  = 10;
    localparam int AMAX = 7100;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst;
    logic               in_valid;
    logic signed [15:0] in_angle;
    logic               out_valid;
    logic signed [15:0] cos_out;
    logic signed [15:0] sin_out;

    cordic_sincos uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_angle  (in_angle),
        .out_valid (out_valid),
        .cos_out   (cos_out),
        .sin_out   (sin_out)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int q_ang[$];
    int q_cyc[$];
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int ref_val(input int a, input bit is_sin);
        real t;
        t = real'(a) / 4096.0;
        return $rtoi($floor((is_sin ? $sin(t) : $cos(t)) * 4096.0 + 0.5));
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_out();
        bit exp_v;
        int a;
        int ec;
        int es;
        string rq;
        longint nrm;
        exp_v = (q_cyc.size() > 0) && (q_cyc[0] + LAT == cyc);
        if (exp_v && !out_valid)      chk(0, "R2", "missing out_valid", 0, 1);
        else if (!exp_v && out_valid) chk(0, "R9", "unexpected out_valid", 1, 0);
        else                          chk(1, "R3", "valid slot", out_valid, exp_v);
        if (exp_v && out_valid) begin
            a  = q_ang.pop_front();
            void'(q_cyc.pop_front());
            ec = ref_val(a, 0);
            es = ref_val(a, 1);
            rq = (iabs(a) >= 7000) ? "R8" : (a == 0) ? "R6" : "R4";
            chk(iabs(int'(cos_out) - ec) <= TOL, rq, "cos", cos_out, ec);
            rq = (iabs(a) >= 7000) ? "R8" : (a == 0) ? "R6" : "R5";
            chk(iabs(int'(sin_out) - es) <= TOL, rq, "sin", sin_out, es);
            nrm = longint'(cos_out) * cos_out + longint'(sin_out) * sin_out;
            chk(nrm >= 16646144 && nrm <= 16908288, "R7", "norm", nrm, 16777216);
        end else if (exp_v) begin
            void'(q_ang.pop_front());
            void'(q_cyc.pop_front());
        end
    endtask

    task automatic step(input bit v, input int a);
        @(negedge clk);
        cyc++;
        check_out();
        in_valid = v;
        in_angle = 16'(a);
        if (v) begin
            q_ang.push_back(a);
            q_cyc.push_back(cyc);
        end
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            rst      = 1'b1;
            in_valid = 1'b1;
            in_angle = 16'(1234);
            if (i > 0) begin
                chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
                chk(cos_out == 0 && sin_out == 0, "R1", "data in reset", cos_out, 0);
            end
        end
        q_ang.delete();
        q_cyc.delete();
        @(negedge clk);
        cyc++;
        chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        chk(cos_out == 0 && sin_out == 0, "R1", "data after reset", sin_out, 0);
        rst      = 1'b0;
        in_valid = 1'b0;
        in_angle = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_angle = '0;
        do_reset(4);

        // R6: zero angle; directed corners back-to-back (R3)
        step(1, 0);
        step(1, 1);
        step(1, -1);
        step(1, 3217);
        step(1, -3217);
        step(1, 6434);
        step(1, -6434);
        step(1, AMAX);
        step(1, -AMAX);
        step(1, 100);
        // R9: idle slots carry garbage angles
        for (int i = 0; i < LAT + 4; i++) step(0, int'($urandom_range(0, 65535)) - 32768);
        step(1, 2000);
        step(0, 32767);
        step(1, -2000);
        for (int i = 0; i < LAT + 2; i++) step(0, 0);

        // random stream with gaps (R2, R3, R4, R5)
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, int'($urandom_range(0, 2 * AMAX)) - AMAX);
        end
        for (int i = 0; i < 20; i++) step(1, int'($urandom_range(0, 2 * AMAX)) - AMAX);

        // R1: reset mid-stream flushes samples in flight
        do_reset(2);
        for (int i = 0; i < LAT + 3; i++) step(0, 555);
        step(1, 4000);
        for (int i = 0; i < LAT + 3; i++) step(0, 0);
        chk(q_ang.size() == 0, "R3", "samples left undelivered", q_ang.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule